// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs single four-state bus cycles (T1, T2, T3, T4) on a narrow bus whose low eight lines carry first the address and then the data. A requester presents a 20-bit address, a direction flag, a memory/port flag and a write byte. The block then walks through the four states. In T1 it emits the address together with a one-cycle latch-enable pulse. In T2 and T3 it either releases the low lines and pulls the read strobe, or puts the write byte on them and pulls the write strobe. In T4 it lets go of everything.

Read data is taken from the bus at the end of T3 and is held until the next read completes. The block also keeps an internal copy of the address, captured as the latch-enable pulse falls, as an external address latch would. A new request is taken only when the block is idle or in T4, so cycles can run back to back with no idle gap.

Top module: `mux_bus_sequencer`

## Requirements
- R1: After reset and whenever idle, the outputs take these values: `busy`=0, `ale`=0, `rd_n`=1, `wr_n`=1, `den_n`=1, `dt_r`=1, `io_sel`=0, `ad_oe`=0, `hi_oe`=0, `rd_valid`=0. Any output bus that is not enabled reads as 0.
- R2: In the first cycle after a request is accepted (T1), the outputs are as follows:
  - `ale`=1, `ad_oe`=1 and `hi_oe`=1.
  - `ad_out` carries address bits 7..0 and `hi_out` carries address bits 19..8.
  - `ale` is high for exactly one cycle.
- R3: For a port cycle (`req_io`=1), `io_sel` is 1 from T1 through T4 and address bits 19..16 are driven as 0. For a memory cycle, `io_sel` is 0 throughout.
- R4: For a read, `dt_r`=0 in T1, T2 and T3. In T2 and T3 the outputs are as follows:
  - `ad_oe`=0, so the low lines are released.
  - `rd_n`=0 and `den_n`=0, while `wr_n` stays 1.
  - `hi_oe`=1, with the upper address still on `hi_out`.
- R5: For a write, `dt_r` stays 1 for the whole cycle. In T2 and T3 the outputs are `ad_oe`=1, `ad_out`=write byte, `wr_n`=0 and `den_n`=0, while `rd_n` stays 1.
- R6: A read samples `ad_in` on the clock edge that ends T3. The sampled byte appears on `rd_data` in T4, with `rd_valid`=1 for that one cycle. `rd_data` keeps its value until the next read samples.
- R7: In T4 the outputs are `rd_n`=1, `wr_n`=1, `den_n`=1, `dt_r`=1, `ad_oe`=0 and `hi_oe`=0, while `busy` is still 1.
- R8: `addr_latch` takes the 20-bit value on {`hi_out`,`ad_out`} at the clock edge where `ale` falls. It holds that value until the next such edge; after reset it is 0.
- R9: `req` is ignored in T1, T2 and T3. It is accepted in idle or T4, and a request accepted in T4 starts T1 on the next cycle.
- R10: `busy` is 1 exactly from T1 through T4 of each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a bus cycle |
| req_addr | input | 20 | Cycle address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = port cycle, 0 = memory cycle |
| req_wdata | input | 8 | Write byte |
| ad_in | input | 8 | Low bus lines as seen from outside |
| busy | output | 1 | Cycle in progress |
| ale | output | 1 | Address latch enable pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data transceiver enable, active low |
| io_sel | output | 1 | 1 = port cycle, 0 = memory cycle |
| dt_r | output | 1 | Transceiver direction, 1 = transmit, 0 = receive |
| ad_oe | output | 1 | Drive enable for the low bus lines |
| ad_out | output | 8 | Value driven on the low bus lines |
| hi_oe | output | 1 | Drive enable for the upper address lines |
| hi_out | output | 12 | Value driven on address lines 19..8 |
| addr_latch | output | 20 | Address captured on the falling edge of `ale` |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | `rd_data` updated this cycle |

## Verification
A wrong state encoding or transition shows on the strobes in the very next cycle. A skipped or repeated state appears as a strobe that is low for one cycle or three instead of two. A stuck state leaves `busy` high past T4. A wrong captured direction flag swaps the low-line enable and the `dt_r` level from T1 onward. A request taken in the middle of a cycle shows up one cycle later as a second `ale` pulse or as a changed `addr_latch`. A sample taken on the wrong edge shows as a wrong `rd_data` in T4.

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer #(
  parameter int AW    = 20,
  parameter int DW    = 8,
  parameter int IO_AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_in,
  output logic          busy,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          io_sel,
  output logic          dt_r,
  output logic          ad_oe,
  output logic [DW-1:0] ad_out,
  output logic          hi_oe,
  output logic [AW-DW-1:0] hi_out,
  output logic [AW-1:0] addr_latch,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int HW = AW - DW;
  localparam logic [AW-1:0] IO_MASK = {{(AW-IO_AW){1'b0}}, {IO_AW{1'b1}}};

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_T4} state_t;
  state_t state;

  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_wdata;
  logic          c_wr, c_io;
  logic          accept, data_ph;

  assign accept  = req && (state == S_IDLE || state == S_T4);
  assign data_ph = (state == S_T2) || (state == S_T3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      c_addr     <= '0;
      c_wdata    <= '0;
      c_wr       <= 1'b0;
      c_io       <= 1'b0;
      addr_latch <= '0;
      rd_data    <= '0;
    end else begin
      case (state)
        S_IDLE:  state <= accept ? S_T1 : S_IDLE;
        S_T1:    state <= S_T2;
        S_T2:    state <= S_T3;
        S_T3:    state <= S_T4;
        default: state <= accept ? S_T1 : S_IDLE;
      endcase
      if (accept) begin
        c_addr  <= req_io ? (req_addr & IO_MASK) : req_addr;
        c_wdata <= req_wdata;
        c_wr    <= req_write;
        c_io    <= req_io;
      end
      if (state == S_T1) addr_latch <= {hi_out, ad_out};
      if (state == S_T3 && !c_wr) rd_data <= ad_in;
    end
  end

  assign busy     = (state != S_IDLE);
  assign ale      = (state == S_T1);
  assign rd_n     = !(data_ph && !c_wr);
  assign wr_n     = !(data_ph && c_wr);
  assign den_n    = !data_ph;
  assign io_sel   = busy && c_io;
  assign dt_r     = !(busy && state != S_T4 && !c_wr);
  assign ad_oe    = ale || (data_ph && c_wr);
  assign ad_out   = ale ? c_addr[DW-1:0] : (ad_oe ? c_wdata : '0);
  assign hi_oe    = ale || data_ph;
  assign hi_out   = hi_oe ? c_addr[AW-1:DW] : {HW{1'b0}};
  assign rd_valid = (state == S_T4) && !c_wr;

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_busy_starts_with_ale_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ale);
  assert_io_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale) |-> $stable(io_sel));
  assert_read_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!dt_r && !ad_oe && !den_n && wr_n));
  assert_write_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (dt_r && ad_oe && !den_n && rd_n));
  assert_latch_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> addr_latch == $past({hi_out, ad_out}));
  assert_t4_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale && !$past(ale) && den_n) |-> (!ad_oe && !hi_oe && dt_r));
endmodule

// File: tb/mux_bus_sequencer_test.sv
module mux_bus_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ad_in = '0;
  logic busy, ale, rd_n, wr_n, den_n, io_sel, dt_r, ad_oe, hi_oe, rd_valid;
  logic [7:0]  ad_out, rd_data;
  logic [11:0] hi_out;
  logic [19:0] addr_latch;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] last_rv = '0;

  always #5 clk = ~clk;

  mux_bus_sequencer uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_write(req_write),
    .req_io(req_io), .req_wdata(req_wdata), .ad_in(ad_in), .busy(busy), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .io_sel(io_sel), .dt_r(dt_r),
    .ad_oe(ad_oe), .ad_out(ad_out), .hi_oe(hi_oe), .hi_out(hi_out),
    .addr_latch(addr_latch), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {busy,ale,rd_n,wr_n,den_n,io_sel,dt_r,ad_oe,ad_out,hi_oe,hi_out,rd_valid}
  function automatic logic [29:0] exp_pins(int ph, bit w, bit io, logic [19:0] a, logic [7:0] d);
    logic [29:0] v;
    bit dp = (ph == 2 || ph == 3);
    v = {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 12'h000, 1'b0};
    if (ph != 0) begin
      v[29] = 1'b1;
      v[24] = io;
      v[23] = (w || ph == 4);
    end
    if (ph == 1) begin
      v[28] = 1'b1; v[22] = 1'b1; v[21:14] = a[7:0]; v[13] = 1'b1; v[12:1] = a[19:8];
    end
    if (dp) begin
      v[25] = 1'b0; v[13] = 1'b1; v[12:1] = a[19:8];
      if (w) begin v[26] = 1'b0; v[22] = 1'b1; v[21:14] = d; end
      else   v[27] = 1'b0;
    end
    if (ph == 4) v[0] = !w;
    return v;
  endfunction

  function automatic string ph_tag(int ph, bit w);
    case (ph)
      0: return "R1 idle pins";
      1: return "R2 T1 pins";
      4: return "R7 T4 pins";
      default: return w ? "R5 write data phase" : "R4 read data phase";
    endcase
  endfunction

  task automatic pins(int ph, bit w, bit io, logic [19:0] a, logic [7:0] d);
    logic [29:0] act = {busy, ale, rd_n, wr_n, den_n, io_sel, dt_r, ad_oe, ad_out, hi_oe, hi_out, rd_valid};
    logic [29:0] e = exp_pins(ph, w, io, a, d);
    chk(act == e, ph_tag(ph, w), 64'(act), 64'(e));
    chk(busy == (ph != 0), "R10 busy window", 64'(busy), 64'(ph != 0));
  endtask

  task automatic noise_req();
    req = 1'b1; req_write = 1'($urandom); req_io = 1'($urandom);
    req_addr = 20'($urandom); req_wdata = 8'($urandom);
  endtask

  task automatic do_txn(bit w, bit io, logic [19:0] a, logic [7:0] d, logic [7:0] rv, bit noise);
    logic [19:0] ea = io ? {4'h0, a[15:0]} : a;
    req = 1'b1; req_write = w; req_io = io; req_addr = a; req_wdata = d;
    @(negedge clk);
    pins(1, w, io, ea, d);
    if (io) chk(hi_out[11:8] == 4'h0, "R3 port upper bits zero", 64'(hi_out), 64'(ea[19:8]));
    chk(io_sel == io, "R3 io select", 64'(io_sel), 64'(io));
    if (noise) noise_req(); else req = 1'b0;
    @(negedge clk);
    pins(2, w, io, ea, d);
    chk(addr_latch == ea, "R8 latched address", 64'(addr_latch), 64'(ea));
    ad_in = rv;
    if (noise) noise_req();
    @(negedge clk);
    pins(3, w, io, ea, d);
    @(negedge clk);
    pins(4, w, io, ea, d);
    if (!w) last_rv = rv;
    chk(rd_data == last_rv, "R6 read data", 64'(rd_data), 64'(last_rv));
    if (noise) chk(addr_latch == ea, "R9 mid-cycle request ignored", 64'(addr_latch), 64'(ea));
    ad_in = 8'($urandom);
  endtask

  task automatic idle_cycles(int n);
    req = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pins(0, 1'b0, 1'b0, 20'h0, 8'h0);
      chk(rd_data == last_rv, "R6 read data held", 64'(rd_data), 64'(last_rv));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pins(0, 1'b0, 1'b0, 20'h0, 8'h0);
    chk(addr_latch == 20'h0, "R8 latch reset", 64'(addr_latch), 64'h0);
    chk(rd_data == 8'h0, "R6 rd_data reset", 64'(rd_data), 64'h0);

    do_txn(1'b0, 1'b0, 20'hFDAA5, 8'h00, 8'h3C, 1'b0);
    idle_cycles(2);
    do_txn(1'b1, 1'b0, 20'h0072B, 8'hA5, 8'h00, 1'b0);
    idle_cycles(1);
    do_txn(1'b0, 1'b1, 20'hFABCD, 8'h00, 8'hC3, 1'b0);
    idle_cycles(1);
    do_txn(1'b1, 1'b1, 20'hE00FE, 8'h5A, 8'h00, 1'b0);
    do_txn(1'b0, 1'b0, 20'h00000, 8'h00, 8'hFF, 1'b1);
    chk(1'b1, "R9 back-to-back accepted", 64'h0, 64'h0);
    do_txn(1'b1, 1'b0, 20'hFFFFF, 8'hFF, 8'h00, 1'b1);
    idle_cycles(2);

    for (int k = 0; k < 300; k++) begin
      do_txn(1'($urandom), 1'($urandom), 20'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
      if ($urandom % 2 == 0) idle_cycles(1 + int'($urandom % 3));
    end
    idle_cycles(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule